// File: doc/BRIEF.md
# Precise Exception Commit Sequencer

This block sits at the retire end of an in-order-completion pipeline and decides when, and which, exception is launched. Execution units report the exception conditions they detect, tagged with the program-order slot of the faulting instruction, in any order. The block keeps those conditions per slot. It launches one only when that slot has reached the completion stage, which means every older instruction has already retired.

External (asynchronous, precise) requests are latched as they arrive. They are launched only at an instruction boundary, and only after the completed store queue has drained. Machine-check and system-reset requests skip the one-at-a-time rule and pre-empt a running handler. A system-reset launch discards everything else that is pending.

Each launch is a one-cycle pulse. With it come a cause code, the handler vector, a supervisor-mode set pulse and a save strobe for the return address and machine state. A return-from-exception input ends the handler window, so the next pending condition can be considered.

Top module: `exc_commit_seq`

## Requirements
- R1: After reset, take_o, sup_set_o, save_o and in_handler_o are 0 and cause_o is 0.
- R2: A condition reported for tag T is launched only while cmp_busy_i is 1 and cmp_tag_i equals T. take_o pulses at the first clock edge after a cycle in which the condition is stored, the handler flag is clear and that tag is at completion. Conditions on younger tags wait, even if they were reported earlier.
- R3: Once launched, no further launch happens until rfe_i clears in_handler_o. Machine check and system reset are excepted.
- R4: Condition bits of one instruction are launched one per handler entry, lowest bit first: bit0 data fault (cause 4), bit1 illegal opcode (cause 5), bit2 privileged opcode (cause 6), bit3 trap (cause 7). The bits not yet launched stay pending.
- R5: A latched external request (cause 3) is launched only when sq_empty_i is 1 and the completion stage is idle or completing (cmp_done_i). A faulting instruction at completion is served first.
- R6: Machine check (cause 2) and system reset (cause 1) are launched one cycle after being latched, even while in a handler. System reset takes priority over machine check.
- R7: A system-reset launch discards all stored instruction conditions and any pending external or machine-check request.
- R8: vector_o equals VEC_BASE + 0x100 times a slot number: reset 1, machine check 2, data fault 3, external 5, and slot 7 shared by illegal, privileged and trap. cause_o and vector_o hold their values between launches.
- R9: Each take_o pulse comes with sup_set_o. save_o also pulses with it, except on a system-reset launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid_i | input | 1 | Condition report valid |
| rpt_tag_i | input | TAG_W | Program-order slot of the reporting instruction |
| rpt_cond_i | input | 4 | Condition bits (see R4) |
| cmp_busy_i | input | 1 | An instruction occupies the completion stage |
| cmp_tag_i | input | TAG_W | Slot of the instruction at completion |
| cmp_done_i | input | 1 | That instruction completes successfully this cycle |
| sq_empty_i | input | 1 | Completed store queue is empty |
| ext_req_i | input | 1 | External precise exception request |
| mck_req_i | input | 1 | Machine-check request |
| rst_req_i | input | 1 | System-reset exception request |
| rfe_i | input | 1 | Return from exception |
| take_o | output | 1 | Launch pulse |
| cause_o | output | 3 | Cause code of the last launch |
| vector_o | output | ADDR_W | Handler address of the last launch |
| sup_set_o | output | 1 | Supervisor-mode set pulse |
| save_o | output | 1 | Save return address and machine state |
| in_handler_o | output | 1 | A handler is running |

## Verification
The bench builds the block with DEPTH = 4 and VEC_BASE = 0xFFF00000. The four-entry table lets a short run report conditions on a young slot before an old one, and then retire the completion pointer across both. The nonzero base shows that every vector is offset from the parameter and not hard-wired to zero. All four condition bits, the external wait on the store queue and both pre-empting causes are reachable inside a few dozen cycles.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NCOND = 4;

  typedef enum logic [2:0] {
    CS_NONE = 3'd0,
    CS_RST  = 3'd1,
    CS_MCK  = 3'd2,
    CS_EXT  = 3'd3,
    CS_DAT  = 3'd4,
    CS_ILL  = 3'd5,
    CS_PRV  = 3'd6,
    CS_TRP  = 3'd7
  } cause_e;

  // vector slot number for each cause; program-type causes share slot 7
  function automatic logic [3:0] vec_slot(cause_e c);
    case (c)
      CS_RST:                 return 4'd1;
      CS_MCK:                 return 4'd2;
      CS_DAT:                 return 4'd3;
      CS_EXT:                 return 4'd5;
      CS_ILL, CS_PRV, CS_TRP: return 4'd7;
      default:                return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_pend_table.sv
module exc_pend_table
  import exc_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [NCOND-1:0] wr_cond,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [NCOND-1:0] clr_mask,
  input  logic             flush,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [NCOND-1:0] rd_cond
);

  logic [NCOND-1:0] slot_q [DEPTH];
  logic [NCOND-1:0] slot_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      slot_d[i] = slot_q[i];
      if (wr_en && (wr_tag == TAG_W'(i))) slot_d[i] = slot_d[i] | wr_cond;
      if (clr_en && (clr_tag == TAG_W'(i))) slot_d[i] = slot_d[i] & ~clr_mask;
      if (flush) slot_d[i] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else        slot_q[i] <= slot_d[i];
    end

    // R4
    cond_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_tag == TAG_W'(i) && !(wr_en && wr_tag == TAG_W'(i)))
        |=> ((slot_q[i] & $past(clr_mask)) == '0));
  end

  assign rd_cond = slot_q[rd_tag];

endmodule

// File: rtl/exc_cond_pick.sv
module exc_cond_pick
  import exc_seq_pkg::*;
(
  input  logic [NCOND-1:0] cond,
  output logic             any,
  output logic [NCOND-1:0] sel,
  output cause_e           cause
);

  always_comb begin
    sel   = '0;
    cause = CS_NONE;
    for (int b = NCOND - 1; b >= 0; b--) begin
      if (cond[b]) begin
        sel    = '0;
        sel[b] = 1'b1;
        cause  = cause_e'(3'(int'(CS_DAT) + b));
      end
    end
  end

  assign any = |cond;

endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
  import exc_seq_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  cause_e            cause,
  output logic [ADDR_W-1:0] vector
);

  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(32'h100);

  assign vector = VEC_BASE + ADDR_W'(vec_slot(cause)) * STRIDE;

endmodule

// File: rtl/exc_commit_seq.sv
module exc_commit_seq
  import exc_seq_pkg::*;
#(
  parameter int              DEPTH    = 8,
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid_i,
  input  logic [TAG_W-1:0]  rpt_tag_i,
  input  logic [3:0]        rpt_cond_i,
  input  logic              cmp_busy_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  input  logic              cmp_done_i,
  input  logic              sq_empty_i,
  input  logic              ext_req_i,
  input  logic              mck_req_i,
  input  logic              rst_req_i,
  input  logic              rfe_i,
  output logic              take_o,
  output logic [2:0]        cause_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              sup_set_o,
  output logic              save_o,
  output logic              in_handler_o
);

  logic [NCOND-1:0]  head_cond;
  logic [NCOND-1:0]  head_sel;
  logic              head_any;
  cause_e            head_cause;

  logic              fire_d, clr_en, flush;
  cause_e            cause_d;
  logic [ADDR_W-1:0] vec_d;

  logic rst_pend_q, rst_pend_d;
  logic mck_pend_q, mck_pend_d;
  logic ext_pend_q, ext_pend_d;
  logic in_hdl_q,   in_hdl_d;
  logic take_q, sup_q, save_q;
  cause_e            cause_q;
  logic [ADDR_W-1:0] vec_q;

  exc_pend_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (rpt_valid_i),
    .wr_tag   (rpt_tag_i),
    .wr_cond  (rpt_cond_i),
    .clr_en   (clr_en),
    .clr_tag  (cmp_tag_i),
    .clr_mask (head_sel),
    .flush    (flush),
    .rd_tag   (cmp_tag_i),
    .rd_cond  (head_cond)
  );

  exc_cond_pick u_pick (
    .cond  (head_cond),
    .any   (head_any),
    .sel   (head_sel),
    .cause (head_cause)
  );

  exc_vec_map #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
    .cause  (cause_d),
    .vector (vec_d)
  );

  // next-state: arbitration and pending bookkeeping
  always_comb begin
    fire_d  = 1'b0;
    cause_d = CS_NONE;
    clr_en  = 1'b0;
    if (rst_pend_q) begin
      fire_d  = 1'b1;
      cause_d = CS_RST;
    end else if (mck_pend_q) begin
      fire_d  = 1'b1;
      cause_d = CS_MCK;
    end else if (!in_hdl_q) begin
      if (cmp_busy_i && head_any) begin
        fire_d  = 1'b1;
        cause_d = head_cause;
        clr_en  = 1'b1;
      end else if (ext_pend_q && sq_empty_i && (!cmp_busy_i || cmp_done_i)) begin
        fire_d  = 1'b1;
        cause_d = CS_EXT;
      end
    end

    flush      = fire_d && (cause_d == CS_RST);
    rst_pend_d = rst_req_i | (rst_pend_q & ~flush);
    mck_pend_d = mck_req_i | (mck_pend_q & ~(fire_d && (cause_d == CS_MCK)) & ~flush);
    ext_pend_d = ext_req_i | (ext_pend_q & ~(fire_d && (cause_d == CS_EXT)) & ~flush);

    if (fire_d)     in_hdl_d = 1'b1;
    else if (rfe_i) in_hdl_d = 1'b0;
    else            in_hdl_d = in_hdl_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b0;
      mck_pend_q <= 1'b0;
      ext_pend_q <= 1'b0;
      in_hdl_q   <= 1'b0;
      take_q     <= 1'b0;
      sup_q      <= 1'b0;
      save_q     <= 1'b0;
      cause_q    <= CS_NONE;
      vec_q      <= '0;
    end else begin
      rst_pend_q <= rst_pend_d;
      mck_pend_q <= mck_pend_d;
      ext_pend_q <= ext_pend_d;
      in_hdl_q   <= in_hdl_d;
      take_q     <= fire_d;
      sup_q      <= fire_d;
      save_q     <= fire_d && (cause_d != CS_RST);
      if (fire_d) begin
        cause_q <= cause_d;
        vec_q   <= vec_d;
      end
    end
  end

  assign take_o       = take_q;
  assign cause_o      = cause_q;
  assign vector_o     = vec_q;
  assign sup_set_o    = sup_q;
  assign save_o       = save_q;
  assign in_handler_o = in_hdl_q;

  // R3
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hdl_q && !rst_pend_q && !mck_pend_q) |=> !take_o);

  // R5
  ext_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o == CS_EXT) |-> $past(sq_empty_i));

  // R9
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (sup_set_o && (save_o == (cause_o != CS_RST))));

  // R8
  shared_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (cause_o == CS_ILL || cause_o == CS_PRV || cause_o == CS_TRP))
      |-> (vector_o == VEC_BASE + ADDR_W'(32'h700)));

  // R7
  reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && cause_o == CS_RST) |-> (!ext_pend_q || $past(ext_req_i)));

  // R3
  handler_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> in_hdl_q);

endmodule

// File: tb/exc_commit_seq_tb_top.sv
module exc_commit_seq_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 4;
  localparam int          ADDR_W     = 32;
  localparam logic [31:0] BASE       = 32'hFFF0_0000;
  localparam int          TAG_W      = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rpt_valid, cmp_busy, cmp_done, sq_empty;
  logic              ext_req, mck_req, rst_req, rfe;
  logic [TAG_W-1:0]  rpt_tag, cmp_tag;
  logic [3:0]        rpt_cond;
  logic              take, sup_set, save, in_hdl;
  logic [2:0]        cause;
  logic [ADDR_W-1:0] vector;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  exc_commit_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .VEC_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rpt_valid_i(rpt_valid), .rpt_tag_i(rpt_tag), .rpt_cond_i(rpt_cond),
    .cmp_busy_i(cmp_busy), .cmp_tag_i(cmp_tag), .cmp_done_i(cmp_done),
    .sq_empty_i(sq_empty), .ext_req_i(ext_req), .mck_req_i(mck_req),
    .rst_req_i(rst_req), .rfe_i(rfe),
    .take_o(take), .cause_o(cause), .vector_o(vector),
    .sup_set_o(sup_set), .save_o(save), .in_handler_o(in_hdl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_take(input string req, input logic [2:0] c, input logic [3:0] slot, input logic sv);
    check({req, " take"}, 32'(take), 32'd1);
    check({req, " cause"}, 32'(cause), 32'(c));
    check({req, " vector"}, vector, BASE + 32'(slot) * 32'h100);
    check({req, " sup_set"}, 32'(sup_set), 32'd1);
    check({req, " save"}, 32'(save), 32'(sv));
  endtask

  task automatic do_rfe();
    rfe = 1'b1;
    tick();
    rfe = 1'b0;
    check("R3 rfe clears handler", 32'(in_hdl), 32'd0);
  endtask

  task automatic t_reset();
    rpt_valid = 0; rpt_tag = 0; rpt_cond = 0;
    cmp_busy = 0; cmp_tag = 0; cmp_done = 0; sq_empty = 1;
    ext_req = 0; mck_req = 0; rst_req = 0; rfe = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 take", 32'(take), 0);
    check("R1 sup_set", 32'(sup_set), 0);
    check("R1 save", 32'(save), 0);
    check("R1 in_handler", 32'(in_hdl), 0);
    check("R1 cause", 32'(cause), 0);
  endtask

  // R2: younger slot reported first, older slot launched first
  task automatic t_order();
    cmp_busy = 1; cmp_tag = 0;
    rpt_valid = 1; rpt_tag = 3; rpt_cond = 4'b0001;
    tick();
    rpt_tag = 1; rpt_cond = 4'b1000;
    tick();
    rpt_valid = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R2 no take while older at completion", 32'(take), 0);
    end
    cmp_done = 1;
    tick();
    cmp_done = 0; cmp_tag = 1;
    check("R2 no take on clean retire", 32'(take), 0);
    tick();
    expect_take("R2 slot1 trap", 3'd7, 4'd7, 1'b1);
    tick();
    check("R3 held in handler", 32'(take), 0);
    do_rfe();
    cmp_tag = 3;
    tick();
    expect_take("R2 slot3 data fault", 3'd4, 4'd3, 1'b1);
    do_rfe();
    cmp_busy = 0;
  endtask

  // R4: two conditions on one instruction, one per handler entry
  task automatic t_multi();
    cmp_busy = 1; cmp_tag = 2;
    rpt_valid = 1; rpt_tag = 2; rpt_cond = 4'b0110;
    tick();
    rpt_valid = 0;
    tick();
    expect_take("R4 illegal first", 3'd5, 4'd7, 1'b1);
    tick();
    check("R4 second waits", 32'(take), 0);
    do_rfe();
    tick();
    expect_take("R4 privileged second", 3'd6, 4'd7, 1'b1);
    tick();
    check("R8 cause holds", 32'(cause), 32'd6);
    do_rfe();
    tick();
    check("R4 slot empty", 32'(take), 0);
    cmp_busy = 0;
  endtask

  // R5: external waits for completion boundary and drained store queue
  task automatic t_async();
    cmp_busy = 1; cmp_tag = 0; sq_empty = 1;
    ext_req = 1;
    tick();
    ext_req = 0;
    tick();
    check("R5 busy not done", 32'(take), 0);
    sq_empty = 0; cmp_done = 1;
    tick();
    check("R5 store queue not empty", 32'(take), 0);
    sq_empty = 1; cmp_done = 1;
    tick();
    cmp_done = 0;
    expect_take("R5 external", 3'd3, 4'd5, 1'b1);
    do_rfe();
    // faulting instruction beats a pending external
    ext_req = 1; rpt_valid = 1; rpt_tag = 0; rpt_cond = 4'b0001;
    tick();
    ext_req = 0; rpt_valid = 0;
    tick();
    expect_take("R5 fault before external", 3'd4, 4'd3, 1'b1);
    do_rfe();
    cmp_busy = 0;
    tick();
    expect_take("R5 external after fault", 3'd3, 4'd5, 1'b1);
    do_rfe();
  endtask

  // R6: machine check pre-empts a running handler
  task automatic t_preempt();
    cmp_busy = 0; sq_empty = 1; ext_req = 1;
    tick();
    ext_req = 0;
    tick();
    expect_take("R6 setup external", 3'd3, 4'd5, 1'b1);
    mck_req = 1;
    tick();
    mck_req = 0;
    tick();
    expect_take("R6 machine check in handler", 3'd2, 4'd2, 1'b1);
    mck_req = 1; rst_req = 1;
    tick();
    mck_req = 0; rst_req = 0;
    tick();
    expect_take("R6 reset beats machine check", 3'd1, 4'd1, 1'b0);
    tick();
    check("R7 machine check discarded", 32'(take), 0);
    do_rfe();
  endtask

  // R7: system reset discards pending conditions
  task automatic t_sysreset();
    cmp_busy = 1; cmp_tag = 0; sq_empty = 0;
    rpt_valid = 1; rpt_tag = 1; rpt_cond = 4'b0001; ext_req = 1;
    tick();
    rpt_valid = 0; ext_req = 0; rst_req = 1;
    tick();
    rst_req = 0;
    tick();
    expect_take("R9 reset without save", 3'd1, 4'd1, 1'b0);
    do_rfe();
    cmp_tag = 1; sq_empty = 1;
    for (int k = 0; k < 2; k++) begin
      tick();
      check("R7 instruction condition discarded", 32'(take), 0);
    end
    cmp_busy = 0;
    for (int k = 0; k < 2; k++) begin
      tick();
      check("R7 external discarded", 32'(take), 0);
    end
    check("R8 vector holds", vector, BASE + 32'h100);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_order();
        t_multi();
        t_async();
        t_preempt();
        t_sysreset();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule